// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 4-bit context number and a 32-bit virtual address into a physical address by reading translation tables that sit in ordinary memory. It starts at a context table whose base comes from a pointer register. From there it follows three typed pointer entries, through region, segment and page tables, to a final page entry. That entry's 3-bit access code is checked against the access kind (read, write or execute) and the privilege (user or supervisor).

A successful walk returns a 36-bit physical address and a cacheable flag. If the walk changes the page entry's referenced or modified flags, the new entry is written back to memory first. A failed walk reports the level it reached and the kind of fault. The walker uses one request/acknowledge memory port and keeps at most one access in flight. A new translation is accepted only while the block is idle.

Top module: `page_walker`

## Requirements
- R1: After reset, busy, mem_req, done and fault are all low.
- R2: The first read goes to byte address {ptr_reg[27:2], 6'b0} | (ctx << 2), which is the pointer register shifted right by 2 and then left by 6, ORed with the context times 4.
- R3: For the next level, the table base is (entry with bits 1:0 cleared) << 4, truncated to 32 bits. The entry address is that base plus 4 times the index. The index is va[31:24] for the region table, va[23:18] for the segment table and va[17:12] for the page table.
- R4: The entry type is held in bits 1:0, with 0 = invalid, 1 = pointer, 2 = page entry and 3 = reserved. The context, region and segment entries must each be pointers. Otherwise the walk ends with fault_level set to the level (0 = context, 1 = region, 2 = segment) and fault_kind set to 1 for an invalid entry or 2 for any other type.
- R5: The page-level entry (level 3) must be a page entry. Otherwise the walk faults at level 3 with kind 1 (invalid) or kind 2 (any other type).
- R6: User rights for access codes 0 to 7 in bits 4:2 are: R, RW, RX, RWX, X, R, none, none. A disallowed access faults with kind 3 at level 3.
- R7: Supervisor rights for access codes 0 to 7 are: R, RW, RX, RWX, X, RW, RX, RWX. access_op encodes 0 = read, 1 = write, 2 = execute and 3 = read.
- R8: A permitted access sets the referenced bit (bit 5), and also sets the modified bit (bit 6) on a write. The entry is written back to the same address only when its value changes. A faulting walk writes nothing.
- R9: On success, phys_addr is {entry[31:8], va[11:0]} and cacheable is entry bit 7.
- R10: mem_req stays asserted with a stable address and write flag until mem_ack. done is a one-cycle pulse. req_valid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_reg | input | 32 | Context table pointer register |
| req_valid | input | 1 | Start a translation (taken when idle) |
| req_ctx | input | 4 | Context number |
| req_va | input | 32 | Virtual address |
| access_op | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_level | output | 2 | Level where the fault occurred |
| fault_kind | output | 2 | 1 invalid, 2 wrong type, 3 protection |
| phys_addr | output | 36 | Translated physical address |
| cacheable | output | 1 | Page is cacheable |

## Verification
The decode of the final entry makes the permission verdict and the write-back decision in the same acknowledge cycle. The riskiest case is a write that is refused while the modified bit is still clear. The vector table provokes it with user writes under codes 0 and 5 on entries whose modified bit is clear. The bench then checks three things: the fault kind, that the memory model logged no write, and that the entry in memory is bit-for-bit unchanged. Entries that already carry both flags check the opposite corner: a permitted access that must complete without any write.

// File: rtl/page_walker.sv
module page_walker #(
  parameter int VA_W  = 32,
  parameter int PPN_W = 24,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            ptr_reg,
  input  logic                   req_valid,
  input  logic [3:0]             req_ctx,
  input  logic [VA_W-1:0]        req_va,
  input  logic [1:0]             access_op,
  input  logic                   req_user,
  output logic                   busy,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [31:0]            mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic                   mem_ack,
  input  logic [31:0]            mem_rdata,
  output logic                   done,
  output logic                   fault,
  output logic [1:0]             fault_level,
  output logic [1:0]             fault_kind,
  output logic [PPN_W+OFF_W-1:0] phys_addr,
  output logic                   cacheable
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;
  state_t st;
  logic [1:0]      lvl, op_q;
  logic            user_q;
  logic [VA_W-1:0] va_q;
  logic [31:0]     addr_q, wdata_q;

  wire [1:0]  etype = mem_rdata[1:0];
  wire [2:0]  code  = mem_rdata[4:2];
  wire [31:0] upd   = mem_rdata | 32'h20 | ((op_q == 2'd1) ? 32'h40 : 32'h0);
  wire [1:0]  bad_kind = (etype == 2'd0) ? 2'd1 : 2'd2;

  logic ok_r, ok_w, ok_x, allow;
  always_comb begin
    if (user_q) begin
      ok_r = code inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5};
      ok_w = code inside {3'd1, 3'd3};
      ok_x = code inside {3'd2, 3'd3, 3'd4};
    end else begin
      ok_r = code != 3'd4;
      ok_w = code inside {3'd1, 3'd3, 3'd5, 3'd7};
      ok_x = code inside {3'd2, 3'd3, 3'd4, 3'd6, 3'd7};
    end
    case (op_q)
      2'd1:    allow = ok_w;
      2'd2:    allow = ok_x;
      default: allow = ok_r;
    endcase
  end

  logic [7:0] idx;
  always_comb
    case (lvl)
      2'd0:    idx = va_q[31:24];
      2'd1:    idx = {2'b00, va_q[23:18]};
      default: idx = {2'b00, va_q[17:12]};
    endcase

  wire [31:0] next_addr = {mem_rdata[27:2], 6'b0} + {22'b0, idx, 2'b00};
  wire [31:0] ctx_addr  = {ptr_reg[27:2], 6'b0} | {26'b0, req_ctx, 2'b00};

  assign busy      = st != S_IDLE;
  assign mem_req   = busy;
  assign mem_we    = st == S_WRITE;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  lvl <= '0;  op_q <= '0;  user_q <= 1'b0;
      va_q <= '0;  addr_q <= '0;  wdata_q <= '0;
      done <= 1'b0;  fault <= 1'b0;  fault_level <= '0;  fault_kind <= '0;
      phys_addr <= '0;  cacheable <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_va;  op_q <= access_op;  user_q <= req_user;
          addr_q <= ctx_addr;  lvl <= 2'd0;  st <= S_READ;
          fault <= 1'b0;  fault_level <= '0;  fault_kind <= '0;
          phys_addr <= '0;  cacheable <= 1'b0;
        end
        S_READ: if (mem_ack) begin
          if (lvl != 2'd3) begin
            if (etype == 2'd1) begin
              lvl <= lvl + 2'd1;
              addr_q <= next_addr;
            end else begin
              done <= 1'b1;  fault <= 1'b1;  fault_level <= lvl;
              fault_kind <= bad_kind;  st <= S_IDLE;
            end
          end else if (etype != 2'd2 || !allow) begin
            done <= 1'b1;  fault <= 1'b1;  fault_level <= 2'd3;
            fault_kind <= (etype != 2'd2) ? bad_kind : 2'd3;
            st <= S_IDLE;
          end else begin
            phys_addr <= {mem_rdata[31:8], va_q[OFF_W-1:0]};
            cacheable <= mem_rdata[7];
            if (upd != mem_rdata) begin
              wdata_q <= upd;
              st <= S_WRITE;
            end else begin
              done <= 1'b1;
              st <= S_IDLE;
            end
          end
        end
        S_WRITE: if (mem_ack) begin
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_va,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_level,
  input logic [1:0]  fault_kind,
  input logic [35:0] phys_addr
);
  logic [31:0] va_l;
  always_ff @(posedge clk)
    if (!rst_n) va_l <= '0;
    else if (req_valid && !busy) va_l <= req_va;

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_wb_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5]);
  a_r9_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> phys_addr[11:0] == va_l[11:0]);
  a_r4_fault_kind_set: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> fault_kind != 2'd0);
  a_r6_prot_at_page: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault && fault_kind == 2'd3 |-> fault_level == 2'd3);
endmodule

bind page_walker page_walker_chk u_chk (.*);

// File: tb/page_walker_test.sv
module page_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VA  = 32'h0528_7ABC;
  localparam logic [31:0] PTE_ADDR = 32'h0000_2C1C;
  localparam logic [23:0] PPN = 24'h012345;
  // {code[2:0], c, m, r, op[1:0], user, exp_kind[1:0]}
  localparam int NV = 13;
  localparam logic [10:0] VEC [NV] = '{
    {3'd3,1'b1,1'b0,1'b0,2'd0,1'b1,2'd0},
    {3'd3,1'b0,1'b0,1'b1,2'd1,1'b1,2'd0},
    {3'd0,1'b1,1'b0,1'b1,2'd1,1'b1,2'd3},
    {3'd5,1'b1,1'b0,1'b1,2'd1,1'b1,2'd3},
    {3'd5,1'b1,1'b0,1'b1,2'd1,1'b0,2'd0},
    {3'd6,1'b1,1'b0,1'b1,2'd0,1'b1,2'd3},
    {3'd6,1'b1,1'b0,1'b1,2'd0,1'b0,2'd0},
    {3'd4,1'b1,1'b0,1'b1,2'd0,1'b0,2'd3},
    {3'd4,1'b1,1'b0,1'b1,2'd2,1'b1,2'd0},
    {3'd7,1'b1,1'b1,1'b1,2'd1,1'b0,2'd0},
    {3'd2,1'b1,1'b0,1'b1,2'd2,1'b1,2'd0},
    {3'd1,1'b0,1'b0,1'b0,2'd2,1'b0,2'd3},
    {3'd7,1'b0,1'b0,1'b1,2'd0,1'b1,2'd3}
  };

  logic clk = 0, rst_n = 0;
  logic [31:0] ptr_reg = 32'h100;
  logic req_valid = 0, req_user = 0;
  logic [3:0] req_ctx = 4'd3;
  logic [31:0] req_va = VA;
  logic [1:0] access_op = 0;
  logic busy, mem_req, mem_we, mem_ack, done, fault, cacheable;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] fault_level, fault_kind;
  logic [35:0] phys_addr;

  int checks = 0, failures = 0, cycles = 0;
  logic [31:0] mem [4096];
  logic bd_we = 0, bd_clr = 0;
  logic [31:0] bd_addr = 0, bd_data = 0;
  int wr_cnt = 0, acc_cnt = 0;
  logic [31:0] log_addr [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_walker uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (bd_we) mem[bd_addr[13:2]] <= bd_data;
    if (bd_clr) begin wr_cnt <= 0; acc_cnt <= 0; end
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[13:2]];
      if (acc_cnt < 8) log_addr[acc_cnt] <= mem_addr;
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bd_we = 1; bd_addr = a; bd_data = d;
    @(negedge clk); bd_we = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    if (!done) begin
      failures++;
      $display("FAIL R10 walk timeout actual=0 expected=1");
    end
  endtask

  task automatic walk(input logic [1:0] op, input logic user);
    @(negedge clk); bd_clr = 1;
    @(negedge clk); bd_clr = 0;
    req_valid = 1; access_op = op; req_user = user; req_va = VA; req_ctx = 4'd3;
    @(negedge clk); req_valid = 0;
    wait_done();
  endtask

  initial begin
    if (cycles > 150000) ;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[32'h100C >> 2] = 32'h0000_0201;
    mem[32'h2014 >> 2] = 32'h0000_0281;
    mem[32'h2828 >> 2] = 32'h0000_02C1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 done/fault", {done, fault}, 0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      logic [31:0] pte, exp_pte;
      logic [1:0] kind;
      pte  = {PPN, VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][10:8], 2'b10};
      kind = VEC[v][1:0];
      exp_pte = (kind == 0) ? (pte | 32'h20 | (VEC[v][4:3] == 2'd1 ? 32'h40 : 32'h0)) : pte;
      poke(PTE_ADDR, pte);
      walk(VEC[v][4:3], VEC[v][2]);
      check(kind == 0 ? "R6 R7 no fault" : "R6 R7 protection fault",
            {fault, fault_kind}, {kind != 0, kind});
      if (kind != 0) check("R6 fault level", fault_level, 3);
      else begin
        check("R9 phys_addr", phys_addr, {PPN, VA[11:0]});
        check("R9 cacheable", cacheable, VEC[v][7]);
      end
      @(negedge clk);
      check("R8 entry after walk", mem[PTE_ADDR[13:2]], exp_pte);
      check("R8 write count", wr_cnt, (exp_pte != pte) ? 1 : 0);
      if (v == 0) begin
        check("R2 context entry addr", log_addr[0], 32'h100C);
        check("R3 region entry addr", log_addr[1], 32'h2014);
        check("R3 segment entry addr", log_addr[2], 32'h2828);
        check("R3 page entry addr", log_addr[3], PTE_ADDR);
        check("R8 write-back addr", log_addr[4], PTE_ADDR);
      end
    end

    // R10: request while busy is ignored
    poke(PTE_ADDR, {PPN, 1'b1, 1'b1, 1'b1, 3'd3, 2'b10});
    @(negedge clk); req_valid = 1; access_op = 0; req_user = 1; req_va = VA;
    @(negedge clk); req_va = 32'h0528_7123; access_op = 2'd1;
    @(negedge clk); req_valid = 0;
    wait_done();
    check("R10 ignored request while busy", phys_addr, {PPN, VA[11:0]});
    @(negedge clk);
    check("R10 busy low after done", busy, 0);

    // R4 / R5 type faults
    poke(32'h100C, 32'h0);
    walk(0, 0);
    check("R4 invalid context entry", {fault, fault_level, fault_kind}, {1'b1, 2'd0, 2'd1});
    poke(32'h100C, 32'h0000_0201);
    poke(32'h2014, 32'h0000_0282);
    walk(0, 0);
    check("R4 page entry at region level", {fault, fault_level, fault_kind}, {1'b1, 2'd1, 2'd2});
    poke(32'h2014, 32'h0000_0281);
    poke(32'h2828, 32'h0000_02C3);
    walk(0, 0);
    check("R4 reserved at segment level", {fault, fault_level, fault_kind}, {1'b1, 2'd2, 2'd2});
    poke(32'h2828, 32'h0000_02C1);
    poke(PTE_ADDR, 32'h0000_0101);
    walk(0, 0);
    check("R5 pointer at page level", {fault, fault_level, fault_kind}, {1'b1, 2'd3, 2'd2});
    poke(PTE_ADDR, 32'h0000_01FC);
    walk(0, 0);
    check("R5 invalid page entry", {fault, fault_level, fault_kind}, {1'b1, 2'd3, 2'd1});
    @(negedge clk);
    check("R8 no write on type fault", wr_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule